// File: doc/BRIEF.md
# Sequential Divide-Remainder Unit

This block divides one unsigned 64-bit operand by another and returns the quotient and the remainder in a single operation. Both results carry their own register destination index, so a register file can write them back to two different registers. The caller raises `start` for one cycle with the operands and the two indices. The unit then works through the division one quotient bit per clock, holding `busy` high. When it finishes, it raises `done` for one cycle with both results valid.

Division by zero does not trap. A zero divisor is detected when the operation is accepted. The unit then finishes in a single cycle and reports all-ones for both the quotient and the remainder. A `start` that arrives while an operation is running is dropped without any effect. The unit accepts a new operation in any cycle in which `busy` is low, including the cycle in which `done` is high.

Top module: `divrem_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy` and `done` are both 0.
- R2: A `start` seen at a clock edge with `busy` low and a nonzero `divisor` sets `busy` from the next cycle. `done` then appears exactly DATA_W (64) cycles after that accepting edge, and `busy` falls in the same cycle.
- R3: For a nonzero divisor, `quotient` at `done` equals floor(dividend / divisor) of the accepted operands.
- R4: For a nonzero divisor, `remainder` at `done` equals dividend mod divisor, and so is strictly less than the divisor.
- R5: A zero `divisor` at an accepted `start` raises `done` in the very next cycle with `quotient` and `remainder` both all ones (0xFFFF_FFFF_FFFF_FFFF). `busy` stays low throughout.
- R6: At `done`, `quo_idx` and `rem_idx` equal the `quo_dst` and `rem_dst` values sampled with the accepted `start`.
- R7: A `start` seen while `busy` is high is ignored. It changes neither the results, nor the indices, nor the completion cycle of the running operation, and it produces no `done` of its own.
- R8: `done` is high for exactly one cycle per accepted operation and is never high while `busy` is high.
- R9: A `start` given in the same cycle that `done` is high is accepted, so operations can run back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation (used only while idle) |
| dividend | input | 64 | Unsigned dividend |
| divisor | input | 64 | Unsigned divisor |
| quo_dst | input | 6 | Destination index for the quotient |
| rem_dst | input | 6 | Destination index for the remainder |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results and indices valid |
| quotient | output | 64 | Quotient result |
| remainder | output | 64 | Remainder result |
| quo_idx | output | 6 | Quotient destination index |
| rem_idx | output | 6 | Remainder destination index |

## Verification
When an operation is accepted at a clock edge, its result is due either 64 cycles after that edge (nonzero divisor) or 1 cycle after it (zero divisor). The driver counts clock edges and stores the due cycle with the expected quotient, remainder and indices in a scoreboard queue. The monitor samples on the falling edge. It requires `done` in exactly the stored cycle and flags a late, early or unmatched `done`. This covers ignored starts during a busy period and back-to-back operations.

// File: rtl/divrem_pkg.sv
package divrem_pkg;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 6;

  typedef struct packed {
    logic [IDX_W-1:0] q_idx;
    logic [IDX_W-1:0] r_idx;
  } dst_pair_t;
endpackage

// File: rtl/divrem_step.sv
module divrem_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] part_rem,
  input  logic [W-1:0] part_quo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] next_rem,
  output logic [W-1:0] next_quo
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted  = {part_rem, part_quo[W-1]};
    fits     = shifted >= {1'b0, dvs};
    diff     = shifted - {1'b0, dvs};
    next_rem = fits ? diff[W-1:0] : shifted[W-1:0];
    next_quo = {part_quo[W-2:0], fits};
  end
endmodule

// File: rtl/divrem_core.sv
module divrem_core
  import divrem_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  input  logic [IW-1:0] quo_dst,
  input  logic [IW-1:0] rem_dst,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  quotient,
  output logic [W-1:0]  remainder,
  output logic [IW-1:0] quo_idx,
  output logic [IW-1:0] rem_idx
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] steps_left;
  logic [W-1:0]     dvs_q;
  logic [W-1:0]     rem_n, quo_n;
  logic             accept;

  assign accept = start && !busy;

  divrem_step #(.W(W)) u_step (
    .part_rem (remainder),
    .part_quo (quotient),
    .dvs      (dvs_q),
    .next_rem (rem_n),
    .next_quo (quo_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      steps_left <= '0;
      dvs_q      <= '0;
      quotient   <= '0;
      remainder  <= '0;
      quo_idx    <= '0;
      rem_idx    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        quo_idx <= quo_dst;
        rem_idx <= rem_dst;
        if (divisor == '0) begin
          quotient  <= '1;
          remainder <= '1;
          done      <= 1'b1;
        end else begin
          busy       <= 1'b1;
          dvs_q      <= divisor;
          quotient   <= dividend;
          remainder  <= '0;
          steps_left <= CNT_W'(W);
        end
      end else if (busy) begin
        quotient   <= quo_n;
        remainder  <= rem_n;
        steps_left <= steps_left - 1'b1;
        if (steps_left == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor != '0) |=> busy);

  assert_steps_live_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (steps_left != '0));

  assert_rem_below_R4: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> (remainder < dvs_q));

  assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=>
      (done && !busy && quotient == '1 && remainder == '1));

  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(quo_idx) && $stable(rem_idx) && $stable(dvs_q)));

  assert_no_done_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/divrem_unit.sv
module divrem_unit
  import divrem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  input  logic [IDX_W-1:0]  quo_dst,
  input  logic [IDX_W-1:0]  rem_dst,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic [IDX_W-1:0]  quo_idx,
  output logic [IDX_W-1:0]  rem_idx
);
  divrem_core #(.W(DATA_W), .IW(IDX_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .quo_dst   (quo_dst),
    .rem_dst   (rem_dst),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .quo_idx   (quo_idx),
    .rem_idx   (rem_idx)
  );
endmodule

// File: tb/divrem_unit_tb.sv
`timescale 1ns/1ps
module divrem_unit_tb;
  localparam int W = 64;
  localparam int IW = 6;
  localparam int WATCHDOG = 100000;

  typedef struct {
    logic [W-1:0]  q;
    logic [W-1:0]  r;
    logic [IW-1:0] qi;
    logic [IW-1:0] ri;
    int            due;
    bit            zero;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic [IW-1:0] quo_dst = '0, rem_dst = '0;
  logic busy, done;
  logic [W-1:0] quotient, remainder;
  logic [IW-1:0] quo_idx, rem_idx;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  exp_t sb[$];
  logic [W-1:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  divrem_unit u_dut (
    .clk(clk), .rst(rst), .start(start),
    .dividend(dividend), .divisor(divisor),
    .quo_dst(quo_dst), .rem_dst(rem_dst),
    .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder),
    .quo_idx(quo_idx), .rem_idx(rem_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Driver: waits for idle, issues one operation, pushes its expectation.
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [IW-1:0] qd, input logic [IW-1:0] rd);
    exp_t e;
    while (busy) @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; quo_dst = qd; rem_dst = rd;
    e.zero = (b == '0);
    e.q  = e.zero ? '1 : a / b;
    e.r  = e.zero ? '1 : a % b;
    e.qi = qd; e.ri = rd;
    e.due = cyc + (e.zero ? 1 : W + 1);
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Start pulse while busy: no expectation pushed (R7).
  task automatic poke_busy(input logic [W-1:0] a, input logic [W-1:0] b);
    start = 1'b1; dividend = a; divisor = b; quo_dst = 6'd63; rem_dst = 6'd62;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [W-1:0] nxt(input logic [W-1:0] x);
    logic [W-1:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  // Monitor: pops and compares at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7", "done with no pending operation", {63'b0, done}, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.due, e.zero ? "R5" : "R2", "done cycle", W'(cyc), W'(e.due));
          chk(quotient == e.q, e.zero ? "R5" : "R3", "quotient", quotient, e.q);
          chk(remainder == e.r, e.zero ? "R5" : "R4", "remainder", remainder, e.r);
          chk(quo_idx == e.qi && rem_idx == e.ri, "R6", "indices",
              W'({quo_idx, rem_idx}), W'({e.qi, e.ri}));
          chk(!busy, "R8", "busy low at done", {63'b0, busy}, '0);
        end
      end else if (sb.size() != 0 && cyc > sb[0].due) begin
        chk(1'b0, "R2", "done missing at due cycle", W'(cyc), W'(sb[0].due));
        void'(sb.pop_front());
      end
    end
  end

  task automatic run_all();
    repeat (5) @(negedge clk);
    chk(!busy && !done, "R1", "idle during reset", {62'b0, busy, done}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after reset", {62'b0, busy, done}, '0);

    // R2 / R3 / R4: basic cases, checking busy one cycle after start.
    issue(64'd100, 64'd7, 6'd1, 6'd2);
    chk(busy, "R2", "busy after start", {63'b0, busy}, 64'd1);
    issue('1, 64'd1, 6'd3, 6'd4);
    issue('1, '1, 6'd5, 6'd6);
    issue(64'd5, 64'd10, 6'd7, 6'd8);
    issue(64'h8000_0000_0000_0000, 64'd3, 6'd9, 6'd10);
    // R5: zero divisor, then back to back (R9) after the single-cycle result.
    issue(64'd1234, 64'd0, 6'd11, 6'd12);
    issue(64'd0, 64'd0, 6'd13, 6'd14);
    issue(64'd0, 64'd9, 6'd15, 6'd16);
    // R7: start pulses during a running operation are ignored.
    issue(64'hDEAD_BEEF_CAFE_F00D, 64'h1_0000, 6'd17, 6'd18);
    poke_busy(64'd1, 64'd0);
    repeat (3) @(negedge clk);
    poke_busy(64'd77, 64'd5);
    // R3 / R4 / R9: pseudo-random operands with varied divisor sizes.
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] a, b;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed >> (seed[5:0]);
      if (i % 7 == 3) b = '0;
      issue(a, b, IW'(i), IW'(63 - i));
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!busy && !done, "R8", "idle after drain", {62'b0, busy, done}, '0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=<%0d", cyc, WATCHDOG);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule